// File: doc/BRIEF.md
# Column-Bypass Unsigned Array Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. The arithmetic core is a square grid of carry-save cells. Each row of the grid handles one bit of the multiplier. Each column handles one bit of the multiplicand. A row whose multiplier bit is 0 adds nothing, so the partial product passes down to the next row unchanged. A column whose multiplicand bit is 0 is bypassed: every cell in that column forwards its incoming partial-product bit through a 2:1 mux and drives its carry to zero. That column therefore does not toggle, whatever the multiplier holds.

The carries in the grid stay in their own column from row to row. Because of this, a bypassed column never receives a carry, and bypassing it never changes the result. A ripple-carry row below the grid merges the last carry vector with the last sum vector to form the upper half of the product. The operands are captured in a register when `in_valid` is high. The product is registered on the next clock edge and is flagged with `out_valid`. Results therefore appear two clock edges after an operand pair is accepted, and a new pair can be accepted on every cycle. The width parameter defaults to 4 and is also meant for 8 and 16.

Top module: `cbm_multiplier`

## Requirements
- R1: For N = 4 and every pair of operands, `product` equals `a_in` × `b_in` as unsigned integers, with the least significant bit at position 0.
- R2: `out_valid` is high for exactly one cycle per accepted pair, two rising edges after the edge at which `in_valid` was sampled high. It is never high otherwise. Results leave in the order the pairs were accepted.
- R3: While `out_valid` is low, `product` holds its last value, even when `a_in` and `b_in` change with `in_valid` low.
- R4: A synchronous active-high `rst` clears `product` to 0 and `out_valid` to 0 at the next edge. This discards any pair that is still in flight.
- R5: If either operand is 0, the product is 0.
- R6: All-ones operands give (2^N − 1)², for example 8'hE1 for N = 4 and 16'hFE01 for N = 8.
- R7: A column whose multiplicand bit is 0 produces no carry in any row. Multiplicands with many zero bits, such as single-bit and alternating patterns, still give the exact product.
- R8: For N = 8 and arbitrary operand pairs, `product` equals `a_in` × `b_in`.
- R9: A multiplier equal to 2^k gives the multiplicand shifted left by k places, because every row with a 0 multiplier bit passes its partial product down unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair on `a_in`/`b_in` is accepted at this edge |
| a_in | input | N | Multiplicand, unsigned |
| b_in | input | N | Multiplier, unsigned |
| out_valid | output | 1 | `product` holds a new result this cycle |
| product | output | 2N | Unsigned product |

## Verification
The hardest situation to reach from the ports is a column being bypassed while carries are still moving in the columns on either side of it. Only then does a wrong bypass (a forced carry that should have been consumed, or a lost sum bit) change the product. The stimulus reaches this with multiplicands that have a single 1 bit, with alternating 0x55/0xAA patterns against dense multipliers, and with an exhaustive sweep at N = 4, so that every mix of active and bypassed columns occurs. A reset that arrives between operand capture and product load checks that an in-flight pair is dropped.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    typedef struct packed {
        logic sum;
        logic carry;
    } csa_t;

    function automatic csa_t full_add(input logic x, input logic y, input logic z);
        csa_t r;
        r.sum   = x ^ y ^ z;
        r.carry = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

endpackage

// File: rtl/cbm_cell.sv
module cbm_cell
    import cbm_pkg::*;
(
    input  logic a_bit,
    input  logic b_bit,
    input  logic s_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);
    csa_t add_r;

    always_comb begin
        add_r = full_add(s_in, a_bit & b_bit, c_in);
        if (a_bit) begin
            s_out = add_r.sum;
            c_out = add_r.carry;
        end else begin
            // column idle: partial product passes through, carry held at zero
            s_out = s_in;
            c_out = 1'b0;
        end
    end
endmodule

// File: rtl/cbm_array.sv
module cbm_array #(
    parameter int N = 4
) (
    input  logic [N-1:0] a_op,
    input  logic [N-1:0] b_op,
    output logic [N-1:0] low_bits,
    output logic [N-2:0] last_sum_hi,
    output logic [N-1:0] last_carry,
    output logic [N-1:0] col_carry_any
);
    localparam int CELLS = N * N;

    logic [CELLS-1:0] s_all;
    logic [CELLS-1:0] c_all;

    for (genvar j = 0; j < N; j++) begin : g_row
        for (genvar i = 0; i < N; i++) begin : g_col
            logic s_feed;
            logic c_feed;
            if (j == 0) begin : g_first
                assign s_feed = 1'b0;
                assign c_feed = 1'b0;
            end else if (i == N - 1) begin : g_edge
                assign s_feed = 1'b0;
                assign c_feed = c_all[(j-1)*N + i];
            end else begin : g_inner
                assign s_feed = s_all[(j-1)*N + i + 1];
                assign c_feed = c_all[(j-1)*N + i];
            end
            cbm_cell u_cell (
                .a_bit (a_op[i]),
                .b_bit (b_op[j]),
                .s_in  (s_feed),
                .c_in  (c_feed),
                .s_out (s_all[j*N + i]),
                .c_out (c_all[j*N + i])
            );
        end
        assign low_bits[j] = s_all[j*N];
    end

    assign last_sum_hi = s_all[CELLS-1 : (N-1)*N + 1];
    assign last_carry  = c_all[CELLS-1 : (N-1)*N];

    always_comb begin
        col_carry_any = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                col_carry_any[i] = col_carry_any[i] | c_all[j*N + i];
            end
        end
    end
endmodule

// File: rtl/cbm_ripple.sv
module cbm_ripple
    import cbm_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    output logic [N-1:0] sum,
    output logic         cout
);
    logic [N:0] chain;
    assign chain[0] = 1'b0;

    for (genvar k = 0; k < N; k++) begin : g_bit
        csa_t r;
        assign r            = full_add(x[k], y[k], chain[k]);
        assign sum[k]       = r.sum;
        assign chain[k + 1] = r.carry;
    end

    assign cout = chain[N];
endmodule

// File: rtl/cbm_multiplier.sv
module cbm_multiplier #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [N-1:0]   a_in,
    input  logic [N-1:0]   b_in,
    output logic           out_valid,
    output logic [2*N-1:0] product
);
    localparam int PW = 2 * N;

    typedef struct packed {
        logic [N-1:0] a;
        logic [N-1:0] b;
    } opnd_t;

    opnd_t          op_q;
    logic           v_q;
    logic [N-1:0]   low_bits;
    logic [N-2:0]   last_sum_hi;
    logic [N-1:0]   last_carry;
    logic [N-1:0]   col_carry_any;
    logic [N-1:0]   hi_bits;
    logic           hi_cout;
    logic [PW-1:0]  prod_next;

    cbm_array #(.N(N)) u_array (
        .a_op          (op_q.a),
        .b_op          (op_q.b),
        .low_bits      (low_bits),
        .last_sum_hi   (last_sum_hi),
        .last_carry    (last_carry),
        .col_carry_any (col_carry_any)
    );

    cbm_ripple #(.N(N)) u_ripple (
        .x    (last_carry),
        .y    ({1'b0, last_sum_hi}),
        .sum  (hi_bits),
        .cout (hi_cout)
    );

    assign prod_next = {hi_bits, low_bits};

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q      <= '0;
            v_q       <= 1'b0;
            out_valid <= 1'b0;
            product   <= '0;
        end else begin
            if (in_valid) begin
                op_q <= '{a: a_in, b: b_in};
            end
            v_q       <= in_valid;
            out_valid <= v_q;
            if (v_q) begin
                product <= prod_next;
            end
        end
    end
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
    parameter int N = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic           out_valid,
    input logic [2*N-1:0] product,
    input logic [N-1:0]   a_q,
    input logic [N-1:0]   b_q,
    input logic           v_q,
    input logic [N-1:0]   col_carry_any,
    input logic           hi_cout
);
    p_product_r1: assert property (@(posedge clk) disable iff (rst)
        v_q |=> product == ($past(a_q) * $past(b_q)));

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
        hi_cout == 1'b0);

    p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    p_valid_source_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(v_q));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> $stable(product));

    p_reset_clear_r4: assert property (@(posedge clk)
        rst |=> (product == '0 && !out_valid));

    p_zero_operand_r5: assert property (@(posedge clk) disable iff (rst)
        (v_q && (a_q == '0 || b_q == '0)) |=> product == '0);

    p_idle_column_r7: assert property (@(posedge clk) disable iff (rst)
        (col_carry_any & ~a_q) == '0);
endmodule

bind cbm_multiplier cbm_checker #(.N(N)) u_cbm_checker (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .out_valid     (out_valid),
    .product       (product),
    .a_q           (op_q.a),
    .b_q           (op_q.b),
    .v_q           (v_q),
    .col_carry_any (col_carry_any),
    .hi_cout       (hi_cout)
);

// File: tb/cbm_multiplier_bench.sv
module cbm_multiplier_bench;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iv4 = 1'b0;
    logic [3:0]  a4 = '0;
    logic [3:0]  b4 = '0;
    logic        ov4;
    logic [7:0]  p4;
    logic        iv8 = 1'b0;
    logic [7:0]  a8 = '0;
    logic [7:0]  b8 = '0;
    logic        ov8;
    logic [15:0] p8;

    item_t q4[$];
    item_t q8[$];
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cbm_multiplier #(.N(4)) u_cbm_multiplier (
        .clk(clk), .rst(rst), .in_valid(iv4), .a_in(a4), .b_in(b4),
        .out_valid(ov4), .product(p4)
    );

    cbm_multiplier #(.N(8)) u_cbm_multiplier_w8 (
        .clk(clk), .rst(rst), .in_valid(iv8), .a_in(a8), .b_in(b8),
        .out_valid(ov8), .product(p8)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive4(input logic [3:0] a, input logic [3:0] b, input string tag);
        item_t it;
        @(negedge clk);
        iv4 = 1'b1; a4 = a; b4 = b;
        it.exp = 16'(a) * 16'(b);
        it.tag = tag;
        q4.push_back(it);
    endtask

    task automatic drive8(input logic [7:0] a, input logic [7:0] b, input string tag);
        item_t it;
        @(negedge clk);
        iv8 = 1'b1; a8 = a; b8 = b;
        it.exp = 16'(a) * 16'(b);
        it.tag = tag;
        q8.push_back(it);
    endtask

    task automatic drain();
        @(negedge clk);
        iv4 = 1'b0; iv8 = 1'b0;
        while (q4.size() != 0 || q8.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: compares each result against the scoreboard head
    always @(negedge clk) begin
        item_t it;
        if (ov4) begin
            if (q4.size() == 0) check(1'b0, "R2 out_valid with nothing pending (N=4)", 16'(p4), 16'h0);
            else begin
                it = q4.pop_front();
                check(16'(p4) == it.exp, it.tag, 16'(p4), it.exp);
            end
        end
        if (ov8) begin
            if (q8.size() == 0) check(1'b0, "R2 out_valid with nothing pending (N=8)", p8, 16'h0);
            else begin
                it = q8.pop_front();
                check(p8 == it.exp, it.tag, p8, it.exp);
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] last4;
        repeat (3) @(negedge clk);
        check(p4 == 8'h0 && !ov4, "R4 reset state N=4", 16'(p4), 16'h0);
        check(p8 == 16'h0 && !ov8, "R4 reset state N=8", p8, 16'h0);
        rst = 1'b0;

        // exhaustive sweep for N = 4, streamed back to back
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                if (a == 0 || b == 0)        drive4(4'(a), 4'(b), "R5 zero operand N=4");
                else if (a == 15 && b == 15) drive4(4'(a), 4'(b), "R6 all ones N=4");
                else                         drive4(4'(a), 4'(b), "R1 exhaustive N=4");
            end
        end
        drain();

        // R2: single pair, valid appears after exactly two edges
        drive4(4'd3, 4'd5, "R2 single pair product");
        @(negedge clk);
        iv4 = 1'b0;
        check(!ov4, "R2 out_valid early", 16'(ov4), 16'h0);
        @(negedge clk);
        check(ov4, "R2 out_valid on second edge", 16'(ov4), 16'h1);
        last4 = 8'd15;

        // R3: inputs change with in_valid low, product holds
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            a4 = a4 + 4'd1;
            b4 = b4 - 4'd3;
            check(p4 == last4 && !ov4, "R3 hold while idle", 16'(p4), 16'(last4));
        end

        // R4: reset while a pair is in flight
        drive4(4'd7, 4'd9, "R4 dropped pair");
        @(negedge clk);
        iv4 = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(p4 == 8'h0 && !ov4, "R4 reset drops in-flight pair", 16'(p4), 16'h0);
        rst = 1'b0;
        q4.delete();
        @(negedge clk);
        @(negedge clk);
        check(p4 == 8'h0 && !ov4, "R4 nothing emerges after reset", 16'(p4), 16'h0);

        // N = 8 corners
        drive8(8'h00, 8'hB5, "R5 A zero N=8");
        drive8(8'hB5, 8'h00, "R5 B zero N=8");
        drive8(8'h00, 8'h00, "R5 both zero N=8");
        drive8(8'hFF, 8'hFF, "R6 all ones N=8");
        drive8(8'h55, 8'hAA, "R7 alternating 55xAA");
        drive8(8'hAA, 8'h55, "R7 alternating AAx55");
        drive8(8'h55, 8'hFF, "R7 alternating 55xFF");
        drive8(8'hAA, 8'hFF, "R7 alternating AAxFF");
        for (int k = 0; k < 8; k++) drive8(8'(1 << k), 8'hFF, "R7 single-bit multiplicand");
        drive8(8'h81, 8'hFF, "R7 two distant columns");
        for (int k = 0; k < 8; k++) drive8(8'hC9, 8'(1 << k), "R9 power-of-two multiplier");
        for (int k = 0; k < 300; k++) drive8(8'($urandom), 8'($urandom), "R8 random N=8");
        drain();

        finish_run();
    end
endmodule